// File: doc/BRIEF.md
# Interleaved I/Q Sample Demultiplexer with Pair Alignment

This block is the digital front end of a two-channel converter. One 14-bit word bus runs at the full input clock rate. It carries in-phase (I) and quadrature (Q) samples in turn. Each word arrives with two side bits. A channel bit says which path the word belongs to. An invert bit says whether the word was sent bit-inverted. The block captures the word and both side bits on every rising clock edge and sends the word to its channel. It undoes the inversion, and it converts the word to the unsigned code the converter core needs.

A quasi-static format input selects whether incoming words are signed two's complement or offset binary. The core always gets offset binary: 0 is the minimum, 0x2000 is midscale and 0x3FFF is full scale.

Each I word waits for the Q word that follows it. The two are released together on both outputs with a single strobe, so each output updates at half the clock rate. Measured from its capture edge, the I path is one clock longer than the Q path. A sticky flag records any break in the I-then-Q alternation.

Top module: `iq_pair_frontend`

## Requirements
- R1: A word captured with `chan_is_i` = 1 appears on `i_code`, and a word captured with `chan_is_i` = 0 appears on `q_code`.
- R2: An I word followed by a Q word is released as one pair. `pair_stb` is high for exactly one cycle, with both codes valid in that cycle. Both codes hold their values until the next strobe.
- R3: The pair appears 9 clock edges after the I word's capture edge, which is 8 edges after the Q word's capture edge.
- R4: With `flip` = 1 all 14 bits of that word only are inverted before decoding. With `flip` = 0 the word passes unchanged.
- R5: With `fmt_twos` = 0 (offset binary) the decoded word passes straight to the output code.
- R6: With `fmt_twos` = 1 (two's complement) bit 13 of the word is inverted after the invert stage. Signed 0x0000 maps to 0x2000, 0x1FFF maps to 0x3FFF, and 0x2000 maps to 0x0000.
- R7: The invert stage acts before the format stage. For example, signed word 0x0000 sent with `flip` = 1 gives 0x1FFF.
- R8: Two consecutive I words: the later one replaces the pending I word, and `seq_err` rises and stays high until reset.
- R9: A Q word with no pending I word (two Q words in a row, or a Q word first after reset) is dropped without a strobe, and `seq_err` is raised.
- R10: A synchronous high `rst` sets both codes to midscale 0x2000 and clears `pair_stb` and `seq_err`. After reset, `pair_stb` stays low until a full I/Q pair has crossed the pipeline.
- R11: `pair_stb` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input word clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 14 | Shared interleaved sample bus |
| chan_is_i | input | 1 | 1 = word belongs to I, 0 = word belongs to Q |
| flip | input | 1 | 1 = word was sent bit-inverted |
| fmt_twos | input | 1 | 1 = two's complement input, 0 = offset binary |
| i_code | output | 14 | Offset-binary code for the I converter |
| q_code | output | 14 | Offset-binary code for the Q converter |
| pair_stb | output | 1 | One-cycle strobe marking a new aligned pair |
| seq_err | output | 1 | Sticky alternation error flag |

## Verification
The hardest conditions to reach are the broken alternation patterns. The bus carries a word on every edge, so the stimulus must place exactly two same-channel words back to back. It does this right after a reset, and then confirms which word survives in the first pair that follows. Latency is measured by counting falling edges from a known capture edge, behind a running stream of filler pairs. The directed tests reset the block first so that earlier pairs cannot mask the first strobe.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
    typedef enum logic {
        CH_Q = 1'b0,
        CH_I = 1'b1
    } chan_e;
endpackage

// File: rtl/iqf_decode.sv
module iqf_decode #(
    parameter int W = 14
) (
    input  logic [W-1:0] raw,
    input  logic         inv,
    input  logic         twos,
    output logic [W-1:0] code
);
    logic [W-1:0] unflipped;

    always_comb begin
        unflipped   = raw ^ {W{inv}};
        code        = unflipped;
        code[W-1]   = unflipped[W-1] ^ twos;
    end
endmodule

// File: rtl/iqf_align_pipe.sv
module iqf_align_pipe #(
    parameter int          W       = 29,
    parameter int          DEPTH   = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stage_d, stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                stage_d[0] = rst ? RST_VAL : d;
            end
        end else begin : g_chain
            always_comb begin
                stage_d[0] = rst ? RST_VAL : d;
                for (int k = 1; k < DEPTH; k++) begin
                    stage_d[k] = rst ? RST_VAL : stage_q[k-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/iq_pair_frontend.sv
module iq_pair_frontend #(
    parameter int W     = 14,
    parameter int Q_LAT = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] word_in,
    input  logic         chan_is_i,
    input  logic         flip,
    input  logic         fmt_twos,
    output logic [W-1:0] i_code,
    output logic [W-1:0] q_code,
    output logic         pair_stb,
    output logic         seq_err
);
    import iqf_pkg::*;

    localparam int           DEPTH = Q_LAT - 2;
    localparam int           PW    = 2 * W + 1;
    localparam logic [W-1:0] MID   = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] cap_w;
        chan_e        cap_ch;
        logic         cap_inv;
        logic         cap_v;
        logic         fmt;
        logic [W-1:0] dec_w;
        chan_e        dec_ch;
        logic         dec_v;
        logic [W-1:0] pend_w;
        logic         pend_v;
        logic [W-1:0] pair_i;
        logic [W-1:0] pair_q;
        logic         pair_v;
        logic         err;
    } st_t;

    st_t          s_d, s_q;
    logic [W-1:0] dec_code;
    logic [PW-1:0] pipe_in, pipe_out;

    iqf_decode #(.W(W)) u_decode (
        .raw  (s_q.cap_w),
        .inv  (s_q.cap_inv),
        .twos (s_q.fmt),
        .code (dec_code)
    );

    always_comb begin
        s_d         = s_q;
        s_d.cap_w   = word_in;
        s_d.cap_ch  = chan_e'(chan_is_i);
        s_d.cap_inv = flip;
        s_d.cap_v   = 1'b1;
        s_d.fmt     = fmt_twos;
        s_d.dec_w   = dec_code;
        s_d.dec_ch  = s_q.cap_ch;
        s_d.dec_v   = s_q.cap_v;
        s_d.pair_v  = 1'b0;
        if (s_q.dec_v) begin
            if (s_q.dec_ch == CH_I) begin
                if (s_q.pend_v) s_d.err = 1'b1;
                s_d.pend_w = s_q.dec_w;
                s_d.pend_v = 1'b1;
            end else if (s_q.pend_v) begin
                s_d.pair_i = s_q.pend_w;
                s_d.pair_q = s_q.dec_w;
                s_d.pair_v = 1'b1;
                s_d.pend_v = 1'b0;
            end else begin
                s_d.err = 1'b1;
            end
        end
        if (rst) begin
            s_d.cap_w   = MID;
            s_d.cap_ch  = CH_Q;
            s_d.cap_inv = 1'b0;
            s_d.cap_v   = 1'b0;
            s_d.fmt     = 1'b0;
            s_d.dec_w   = MID;
            s_d.dec_ch  = CH_Q;
            s_d.dec_v   = 1'b0;
            s_d.pend_w  = MID;
            s_d.pend_v  = 1'b0;
            s_d.pair_i  = MID;
            s_d.pair_q  = MID;
            s_d.pair_v  = 1'b0;
            s_d.err     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign pipe_in = {s_q.pair_v, s_q.pair_i, s_q.pair_q};

    iqf_align_pipe #(
        .W       (PW),
        .DEPTH   (DEPTH),
        .RST_VAL ({1'b0, MID, MID})
    ) u_align (
        .clk (clk),
        .rst (rst),
        .d   (pipe_in),
        .q   (pipe_out)
    );

    assign pair_stb = pipe_out[PW-1];
    assign i_code   = pipe_out[2*W-1:W];
    assign q_code   = pipe_out[W-1:0];
    assign seq_err  = s_q.err;

    // R10: reset puts both outputs at midscale with no strobe or error
    p_reset_mid_r10: assert property (@(posedge clk)
        rst |=> (i_code == MID && q_code == MID && !pair_stb && !seq_err));

    // R11: strobes are separated by at least one idle cycle
    p_strobe_gap_r11: assert property (@(posedge clk) disable iff (rst)
        pair_stb |=> !pair_stb);

    // R8: the error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    // R9: two adjacent words on the same channel must end in an error
    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        (s_q.cap_v && s_q.dec_v && s_q.cap_ch == s_q.dec_ch) |-> ##2 seq_err);
endmodule

// File: tb/iq_pair_frontend_tb.sv
module iq_pair_frontend_tb;
    localparam int CLK_P = 10;
    localparam int NV    = 7;
    // fmt | i_word | i_flip | q_word | q_flip | exp_i | exp_q
    localparam logic [58:0] VEC [NV] = '{
        {1'b0, 14'h0000, 1'b0, 14'h3FFF, 1'b0, 14'h0000, 14'h3FFF},
        {1'b0, 14'h0000, 1'b1, 14'h1234, 1'b0, 14'h3FFF, 14'h1234},
        {1'b1, 14'h0000, 1'b0, 14'h1FFF, 1'b0, 14'h2000, 14'h3FFF},
        {1'b1, 14'h2000, 1'b0, 14'h0001, 1'b0, 14'h0000, 14'h2001},
        {1'b1, 14'h0000, 1'b1, 14'h3FFF, 1'b1, 14'h1FFF, 14'h2000},
        {1'b0, 14'h2AAA, 1'b1, 14'h1555, 1'b0, 14'h1555, 14'h1555},
        {1'b1, 14'h3FFF, 1'b0, 14'h2000, 1'b1, 14'h1FFF, 14'h3FFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] word_in = 14'h2000;
    logic        chan_is_i = 1'b1;
    logic        flip = 1'b0;
    logic        fmt_twos = 1'b0;
    logic [13:0] i_code, q_code;
    logic        pair_stb, seq_err;

    int total = 0;
    int bad   = 0;
    int got   = 0;
    bit mon_en = 1'b0;
    bit prev_stb = 1'b0;
    logic [13:0] last_i, last_q;
    bit filler_i = 1'b1;

    iq_pair_frontend u_dut (
        .clk(clk), .rst(rst), .word_in(word_in), .chan_is_i(chan_is_i),
        .flip(flip), .fmt_twos(fmt_twos), .i_code(i_code), .q_code(q_code),
        .pair_stb(pair_stb), .seq_err(seq_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // every drive task starts at a falling edge and ends at the next one
    task automatic put_word(input logic [13:0] w, input bit ch, input bit inv, input bit f);
        word_in = w; chan_is_i = ch; flip = inv; fmt_twos = f;
        @(negedge clk);
    endtask

    task automatic send_pair(input bit f, input logic [13:0] iw, input bit ii,
                             input logic [13:0] qw, input bit qi);
        put_word(iw, 1'b1, ii, f);
        put_word(qw, 1'b0, qi, f);
    endtask

    task automatic filler();
        put_word(14'h2000, filler_i, 1'b0, 1'b0);
        filler_i = ~filler_i;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        filler_i = 1'b1;
    endtask

    // pair monitor for the vector table
    always @(negedge clk) begin
        if (mon_en && got < NV) begin
            if (pair_stb) begin
                chk(i_code == VEC[got][27:14], "R1 i_code", i_code, VEC[got][27:14]);
                chk(q_code == VEC[got][13:0], "R1 q_code", q_code, VEC[got][13:0]);
                chk(!prev_stb, "R11 strobe gap", prev_stb, 0);
                last_i = i_code;
                last_q = q_code;
                got++;
            end else if (got > 0) begin
                chk(i_code == last_i && q_code == last_q, "R2 hold between strobes",
                    {i_code, q_code}, {last_i, last_q});
            end
        end
        prev_stb = pair_stb;
    end

    initial begin
        #(CLK_P * 100000);
        total++;
        bad++;
        $display("FAIL watchdog timeout act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        bit seen;

        // R10: reset state
        do_reset();
        put_word(14'h1111, 1'b1, 1'b0, 1'b0);
        chk(i_code == 14'h2000 && q_code == 14'h2000, "R10 midscale after reset", {i_code, q_code}, 28'h8002000);
        chk(!pair_stb && !seq_err, "R10 strobe/err low", {pair_stb, seq_err}, 0);

        // vector table: R1 R2 R4 R5 R6 R7 R11
        do_reset();
        got = 0;
        mon_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            send_pair(VEC[v][58], VEC[v][57:44], VEC[v][43], VEC[v][42:29], VEC[v][28]);
        end
        for (int c = 0; c < 40 && got < NV; c++) filler();
        mon_en = 1'b0;
        chk(got == NV, "R2 pair count", got, NV);
        chk(!seq_err, "R8 no error on clean alternation", seq_err, 0);

        // R3 latency and R10 strobe held low until first pair
        do_reset();
        send_pair(1'b0, 14'h0ABC, 1'b0, 14'h3210, 1'b0);
        lat = 0;
        seen = 1'b0;
        for (int c = 2; c < 30 && !seen; c++) begin
            if (pair_stb) begin
                seen = 1'b1;
                lat = c - 1;
            end else begin
                filler();
            end
        end
        chk(lat == 9, "R3 I latency", lat, 9);
        chk(i_code == 14'h0ABC && q_code == 14'h3210, "R3 pair contents", {i_code, q_code}, {14'h0ABC, 14'h3210});

        // R8: I, I, Q -> later I kept, error sticky
        do_reset();
        put_word(14'h0111, 1'b1, 1'b0, 1'b0);
        send_pair(1'b0, 14'h0222, 1'b0, 14'h0333, 1'b0);
        filler_i = 1'b1;
        seen = 1'b0;
        for (int c = 0; c < 30 && !seen; c++) begin
            if (pair_stb) seen = 1'b1;
            else filler();
        end
        chk(seen && i_code == 14'h0222, "R8 later I replaces pending", i_code, 14'h0222);
        chk(q_code == 14'h0333, "R8 Q of pair", q_code, 14'h0333);
        chk(seq_err, "R8 error raised", seq_err, 1);
        repeat (6) filler();
        chk(seq_err, "R8 error sticky", seq_err, 1);

        // R9: Q first after reset is dropped
        do_reset();
        put_word(14'h0444, 1'b0, 1'b0, 1'b0);
        send_pair(1'b0, 14'h0555, 1'b0, 14'h0666, 1'b0);
        filler_i = 1'b1;
        seen = 1'b0;
        lat = 0;
        for (int c = 0; c < 30 && !seen; c++) begin
            if (pair_stb) seen = 1'b1;
            else begin filler(); lat++; end
        end
        chk(seen && i_code == 14'h0555 && q_code == 14'h0666, "R9 orphan Q dropped",
            {i_code, q_code}, {14'h0555, 14'h0666});
        chk(seq_err, "R9 error raised", seq_err, 1);

        // R10: reset clears the sticky error
        do_reset();
        put_word(14'h2000, 1'b1, 1'b0, 1'b0);
        chk(!seq_err, "R10 reset clears error", seq_err, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule